// File: doc/BRIEF.md
# Radio Operating Mode Sequencer

This block decides which operating mode a low-power packet radio is in. It looks at three control levels (a power-on bit, a receive-primary bit and a chip-enable pin), a TX queue empty flag and a packet-finished strobe. From these it walks through seven modes: power down, two idle modes, a receive settle mode, receive, a transmit settle mode and transmit. Every timer counts pulses of a microsecond tick input, and every delay is a parameter, so a bench can shorten each one.

The host raises the power-on bit and waits out an oscillator wake interval, which is shorter when an external clock is selected. A receiver is then brought up by holding chip-enable with receive-primary set. A transmitter is brought up by loading the queue and holding chip-enable long enough. Each entry into an active mode, and each switch between receive and transmit, passes through a fixed settle interval. A transmit watchdog ends any transmit mode that runs too long and raises a sticky error flag.

The outputs are a one-hot mode vector, three radio enable levels and a one-cycle strobe that tells the packet engine to start sending.

Top module: `radio_mode_ctrl`

## Requirements
- R1: When `pwr_on` is 0 at a clock edge, the mode after that edge is power down (mode bit 0) and `tx_overrun` is 0, whatever the other inputs are.
- R2: `mode_oh` always has exactly one bit set: bit 0 power down, bit 1 idle-1, bit 2 idle-2, bit 3 RX settle, bit 4 RX, bit 5 TX settle, bit 6 TX.
- R3: After `pwr_on` rises, the block goes to idle-1 and enters no settle mode until WAKE_US ticks have been counted (WAKE_EXT_US ticks when `ext_osc` is 1).
- R4: From idle-1, RX settle is entered only with `rx_primary` = 1 and `chip_en` = 1. In RX settle or RX, `chip_en` = 0 returns the block to idle-1 at the next edge.
- R5: From idle-1, TX settle is entered only with `rx_primary` = 0 and `txq_empty` = 0, after `chip_en` has been high at CE_MIN_US + 1 consecutive ticks.
- R6: RX and TX are entered only from their settle modes. A settle mode lasts exactly SETTLE_US ticks.
- R7: `tx_start` is high for exactly the first cycle of each transmit mode, including a back-to-back packet that stays in TX.
- R8: When `pkt_done` is 1 in TX, the next mode is idle-1 if `chip_en` = 0. Otherwise it is RX settle if `rx_primary` = 1, TX with a new packet if the queue is not empty, and idle-2 if the queue is empty.
- R9: In idle-2, a non-empty queue with `chip_en` = 1 and `rx_primary` = 0 starts TX settle at the next edge. `chip_en` = 0 returns the block to idle-1.
- R10: If TX lasts TX_MAX_US ticks without `pkt_done`, the block goes to idle-1 and `tx_overrun` is set. It stays set until `pwr_on` is 0.
- R11: In RX with `chip_en` = 1, `rx_primary` = 0 turns the radio around to TX settle when the queue is not empty, and to idle-2 when it is empty.
- R12: `chip_en` has no effect in TX settle: the settle runs to its end and TX follows.
- R13: `synth_on` is high in the settle and active modes, `rx_on` only in RX, and `tx_on` only in TX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| ext_osc | input | 1 | Selects the short wake interval |
| pwr_on | input | 1 | Power-on control bit |
| rx_primary | input | 1 | Receive-primary control bit |
| chip_en | input | 1 | Chip-enable level |
| txq_empty | input | 1 | TX queue empty flag |
| pkt_done | input | 1 | Packet sent strobe |
| mode_oh | output | 7 | One-hot operating mode |
| synth_on | output | 1 | Synthesizer enable |
| rx_on | output | 1 | Receiver enable |
| tx_on | output | 1 | Transmitter enable |
| tx_start | output | 1 | Start-of-transmit strobe |
| tx_overrun | output | 1 | Sticky transmit watchdog error |

## Verification
Directed sequences come first. They cover the wake interval with each clock option, a chip-enable pulse one tick too short next to one long enough, chip-enable dropped during a TX settle, back-to-back packets, the drain into idle-2 and a refill from it, a watchdog expiry and both receive/transmit turnarounds. These separate the priority order among the exit conditions and the exact tick counts. A long run with random control levels and an irregular tick pattern follows. It checks every cycle against a bench model, which shows that timers count ticks rather than clock cycles and that they restart on every mode change.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    localparam int NMODES = 7;

    typedef enum logic [2:0] {
        M_OFF   = 3'd0,
        M_IDLE1 = 3'd1,
        M_IDLE2 = 3'd2,
        M_RXSET = 3'd3,
        M_RX    = 3'd4,
        M_TXSET = 3'd5,
        M_TX    = 3'd6
    } rmc_mode_e;

    typedef struct packed {
        logic pwr;
        logic prim_rx;
        logic ce;
        logic empty;
        logic done;
    } rmc_ctl_s;

    function automatic logic [NMODES-1:0] mode_to_onehot(rmc_mode_e m);
        logic [NMODES-1:0] r;
        r = '0;
        r[m] = 1'b1;
        return r;
    endfunction

    function automatic logic is_settle(rmc_mode_e m);
        return (m == M_RXSET) || (m == M_TXSET);
    endfunction

    function automatic logic is_active(rmc_mode_e m);
        return (m == M_RX) || (m == M_TX);
    endfunction

endpackage

// File: rtl/rmc_arm_timer.sv
module rmc_arm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            cnt     <= '0;
            reached <= 1'b0;
        end else if (tick && !reached) begin
            if (cnt >= limit - W'(1)) begin
                reached <= 1'b1;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/rmc_interval_timer.sv
module rmc_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = tick && (cnt >= limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick && (cnt != '1)) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rmc_mode_fsm.sv
module rmc_mode_fsm
    import rmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rmc_ctl_s  ctl,
    input  logic      wake_ok,
    input  logic      ce_long,
    input  logic      tmr_hit,
    output rmc_mode_e mode,
    output logic      tmr_restart,
    output logic      tmr_tx_limit,
    output logic      tx_start,
    output logic      tx_overrun
);
    rmc_mode_e st, nxt;
    logic      again;

    always_comb begin
        nxt   = st;
        again = 1'b0;
        if (!ctl.pwr) begin
            nxt = M_OFF;
        end else begin
            case (st)
                M_OFF: nxt = M_IDLE1;
                M_IDLE1: begin
                    if (wake_ok) begin
                        if (ctl.prim_rx && ctl.ce) begin
                            nxt = M_RXSET;
                        end else if (!ctl.prim_rx && !ctl.empty && ce_long) begin
                            nxt = M_TXSET;
                        end
                    end
                end
                M_IDLE2: begin
                    if (!ctl.ce) begin
                        nxt = M_IDLE1;
                    end else if (ctl.prim_rx) begin
                        nxt = M_RXSET;
                    end else if (!ctl.empty) begin
                        nxt = M_TXSET;
                    end
                end
                M_RXSET: begin
                    if (!ctl.ce) begin
                        nxt = M_IDLE1;
                    end else if (tmr_hit) begin
                        nxt = M_RX;
                    end
                end
                M_RX: begin
                    if (!ctl.ce) begin
                        nxt = M_IDLE1;
                    end else if (!ctl.prim_rx) begin
                        nxt = ctl.empty ? M_IDLE2 : M_TXSET;
                    end
                end
                M_TXSET: begin
                    if (tmr_hit) begin
                        nxt = M_TX;
                    end
                end
                M_TX: begin
                    if (ctl.done) begin
                        if (!ctl.ce) begin
                            nxt = M_IDLE1;
                        end else if (ctl.prim_rx) begin
                            nxt = M_RXSET;
                        end else if (!ctl.empty) begin
                            again = 1'b1;
                        end else begin
                            nxt = M_IDLE2;
                        end
                    end else if (tmr_hit) begin
                        nxt = M_IDLE1;
                    end
                end
                default: nxt = M_OFF;
            endcase
        end
    end

    assign tmr_restart  = (nxt != st) || again;
    assign tmr_tx_limit = (st == M_TX);
    assign mode         = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= M_OFF;
            tx_start   <= 1'b0;
            tx_overrun <= 1'b0;
        end else begin
            st       <= nxt;
            tx_start <= (nxt == M_TX) && ((st != M_TX) || again);
            if (!ctl.pwr) begin
                tx_overrun <= 1'b0;
            end else if ((st == M_TX) && tmr_hit && !ctl.done) begin
                tx_overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
    import rmc_pkg::*;
#(
    parameter int WAKE_US     = 1500,
    parameter int WAKE_EXT_US = 150,
    parameter int SETTLE_US   = 130,
    parameter int CE_MIN_US   = 10,
    parameter int TX_MAX_US   = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              ext_osc,
    input  logic              pwr_on,
    input  logic              rx_primary,
    input  logic              chip_en,
    input  logic              txq_empty,
    input  logic              pkt_done,
    output logic [NMODES-1:0] mode_oh,
    output logic              synth_on,
    output logic              rx_on,
    output logic              tx_on,
    output logic              tx_start,
    output logic              tx_overrun
);
    localparam int WAKE_MAX = (WAKE_US > WAKE_EXT_US) ? WAKE_US : WAKE_EXT_US;
    localparam int WW       = $clog2(WAKE_MAX + 1);
    localparam int CW       = $clog2(CE_MIN_US + 2);
    localparam int TMAX     = (TX_MAX_US > SETTLE_US) ? TX_MAX_US : SETTLE_US;
    localparam int TW       = $clog2(TMAX + 1);

    localparam logic [WW-1:0] WAKE_L     = WW'(WAKE_US);
    localparam logic [WW-1:0] WAKE_EXT_L = WW'(WAKE_EXT_US);
    localparam logic [CW-1:0] CE_L       = CW'(CE_MIN_US + 1);
    localparam logic [TW-1:0] SETTLE_L   = TW'(SETTLE_US);
    localparam logic [TW-1:0] TXMAX_L    = TW'(TX_MAX_US);

    rmc_ctl_s  ctl;
    rmc_mode_e mode;
    logic      wake_ok, ce_long, tmr_hit, tmr_restart, tmr_tx_limit;
    logic [WW-1:0] wake_limit;
    logic [TW-1:0] tmr_limit;

    assign ctl = '{pwr: pwr_on, prim_rx: rx_primary, ce: chip_en,
                   empty: txq_empty, done: pkt_done};

    assign wake_limit = ext_osc ? WAKE_EXT_L : WAKE_L;
    assign tmr_limit  = tmr_tx_limit ? TXMAX_L : SETTLE_L;

    rmc_arm_timer #(.W(WW)) u_wake (
        .clk(clk), .rst(rst), .arm(pwr_on), .tick(us_tick),
        .limit(wake_limit), .reached(wake_ok)
    );

    rmc_arm_timer #(.W(CW)) u_ce (
        .clk(clk), .rst(rst), .arm(chip_en), .tick(us_tick),
        .limit(CE_L), .reached(ce_long)
    );

    rmc_interval_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .restart(tmr_restart), .tick(us_tick),
        .limit(tmr_limit), .hit(tmr_hit)
    );

    rmc_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .ctl(ctl), .wake_ok(wake_ok), .ce_long(ce_long),
        .tmr_hit(tmr_hit), .mode(mode), .tmr_restart(tmr_restart),
        .tmr_tx_limit(tmr_tx_limit), .tx_start(tx_start), .tx_overrun(tx_overrun)
    );

    assign mode_oh  = mode_to_onehot(mode);
    assign synth_on = is_settle(mode) || is_active(mode);
    assign rx_on    = (mode == M_RX);
    assign tx_on    = (mode == M_TX);
endmodule

// File: rtl/rmc_checker.sv
module rmc_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_on,
    input logic       rx_primary,
    input logic       chip_en,
    input logic       txq_empty,
    input logic [6:0] mode_oh,
    input logic       tx_start,
    input logic       tx_overrun
);
    assert_power_down_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> (mode_oh == 7'b0000001) && !tx_overrun);

    assert_one_mode_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_oh) == 1);

    assert_rx_abort_R4: assert property (@(posedge clk) disable iff (rst)
        pwr_on && !chip_en && (mode_oh[3] || mode_oh[4]) |=> mode_oh[1]);

    assert_rx_via_settle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_oh[4]) |-> $past(mode_oh[3]));

    assert_tx_via_settle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_oh[6]) |-> $past(mode_oh[5]));

    assert_start_in_tx_R7: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> mode_oh[6] && ($past(mode_oh[5]) || $past(mode_oh[6])));

    assert_idle2_refill_R9: assert property (@(posedge clk) disable iff (rst)
        mode_oh[2] && pwr_on && chip_en && !rx_primary && !txq_empty |=> mode_oh[5]);

    assert_overrun_exit_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_overrun) |-> mode_oh[1] && $past(mode_oh[6]));
endmodule

bind radio_mode_ctrl rmc_checker u_chk (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .rx_primary(rx_primary),
    .chip_en(chip_en), .txq_empty(txq_empty), .mode_oh(mode_oh),
    .tx_start(tx_start), .tx_overrun(tx_overrun)
);

// File: tb/sim_radio_mode_ctrl.sv
module sim_radio_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE   = 30;
    localparam int WEXT   = 8;
    localparam int SET    = 6;
    localparam int CE_MIN = 4;
    localparam int TXM    = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1, ext_osc = 1'b0, pwr_on = 1'b0, rx_primary = 1'b0;
    logic chip_en = 1'b0, txq_empty = 1'b1, pkt_done = 1'b0;
    logic [6:0] mode_oh;
    logic synth_on, rx_on, tx_on, tx_start, tx_overrun;

    int n_chk = 0, n_fail = 0;
    bit tick_rand = 1'b0;
    bit finished = 1'b0;
    string phase = "";

    // bench model state: 0 off,1 idle1,2 idle2,3 rx settle,4 rx,5 tx settle,6 tx
    int m_st = 0, m_tmr = 0, m_wc = 0, m_cc = 0, lim = 0, nx = 0;
    bit m_wok = 0, m_cok = 0, m_err = 0, m_start = 0, hit = 0, again = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_mode_ctrl #(.WAKE_US(WAKE), .WAKE_EXT_US(WEXT), .SETTLE_US(SET),
                      .CE_MIN_US(CE_MIN), .TX_MAX_US(TXM)) u0 (
        .clk(clk), .rst(rst), .us_tick(tick), .ext_osc(ext_osc), .pwr_on(pwr_on),
        .rx_primary(rx_primary), .chip_en(chip_en), .txq_empty(txq_empty),
        .pkt_done(pkt_done), .mode_oh(mode_oh), .synth_on(synth_on), .rx_on(rx_on),
        .tx_on(tx_on), .tx_start(tx_start), .tx_overrun(tx_overrun)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_tmr = 0; m_wc = 0; m_cc = 0;
            m_wok = 0; m_cok = 0; m_err = 0; m_start = 0;
        end else begin
            lim   = (m_st == 6) ? TXM : SET;
            hit   = tick && (m_tmr >= lim - 1);
            again = 0;
            nx    = m_st;
            if (!pwr_on) nx = 0;
            else case (m_st)
                0: nx = 1;
                1: if (m_wok) begin
                       if (rx_primary && chip_en) nx = 3;
                       else if (!rx_primary && !txq_empty && m_cok) nx = 5;
                   end
                2: if (!chip_en) nx = 1; else if (rx_primary) nx = 3;
                   else if (!txq_empty) nx = 5;
                3: if (!chip_en) nx = 1; else if (hit) nx = 4;
                4: if (!chip_en) nx = 1; else if (!rx_primary) nx = txq_empty ? 2 : 5;
                5: if (hit) nx = 6;
                default: if (pkt_done) begin
                       if (!chip_en) nx = 1; else if (rx_primary) nx = 3;
                       else if (!txq_empty) again = 1; else nx = 2;
                   end else if (hit) nx = 1;
            endcase
            if (!pwr_on) m_err = 0;
            else if (m_st == 6 && hit && !pkt_done) m_err = 1;
            m_start = (nx == 6) && (m_st != 6 || again);
            if (nx != m_st || again) m_tmr = 0;
            else if (tick && m_tmr < 1000000) m_tmr++;
            if (!pwr_on) begin m_wc = 0; m_wok = 0; end
            else if (tick && !m_wok) begin
                if (m_wc >= (ext_osc ? WEXT : WAKE) - 1) m_wok = 1; else m_wc++;
            end
            if (!chip_en) begin m_cc = 0; m_cok = 0; end
            else if (tick && !m_cok) begin
                if (m_cc >= CE_MIN) m_cok = 1; else m_cc++;
            end
            m_st = nx;
        end
    end

    function automatic string st_tag(int s);
        case (s)
            0: return "R1";
            1: return "R3";
            2: return "R9";
            3: return "R6";
            4: return "R4";
            5: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
        end
    endtask

    task automatic compare();
        string t;
        t = (phase != "") ? phase : st_tag(m_st);
        chk(t, "mode_oh", int'(mode_oh), 1 << m_st);
        chk("R2", "one-hot count", $countones(mode_oh), 1);
        chk("R7", "tx_start", int'(tx_start), int'(m_start));
        chk("R10", "tx_overrun", int'(tx_overrun), int'(m_err));
        chk("R13", "enables", int'({synth_on, rx_on, tx_on}),
            int'({(m_st >= 3), (m_st == 4), (m_st == 6)}));
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            tick = tick_rand ? ($urandom % 3 != 0) : 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1"; cyc(3);
        // wake interval with the internal oscillator, then RX
        phase = "R3"; pwr_on = 1; rx_primary = 1; chip_en = 1; cyc(WAKE + SET + 5);
        phase = "R4"; chip_en = 0; cyc(3); chip_en = 1; cyc(3); chip_en = 0; cyc(2);
        // short wake interval with external clock
        phase = "R3"; pwr_on = 0; cyc(2); ext_osc = 1; pwr_on = 1; chip_en = 1;
        cyc(WEXT + SET + 4); chip_en = 0; ext_osc = 0; cyc(2);
        // chip-enable pulse too short, then long enough
        phase = "R5"; rx_primary = 0; txq_empty = 0; chip_en = 1; cyc(CE_MIN);
        chip_en = 0; cyc(4); chip_en = 1; cyc(CE_MIN + 3);
        // chip-enable dropped during TX settle is ignored
        phase = "R12"; chip_en = 0; cyc(SET + 2);
        // back-to-back packet, then drain to idle-2
        phase = "R8"; chip_en = 1; pkt_done = 1; cyc(1); pkt_done = 0; cyc(3);
        pkt_done = 1; txq_empty = 1; cyc(1); pkt_done = 0; cyc(3);
        phase = "R9"; txq_empty = 0; cyc(SET + 3);
        phase = "R10"; cyc(TXM + 4); pwr_on = 0; cyc(2);
        // turnarounds between receive and transmit
        phase = "R11"; pwr_on = 1; rx_primary = 1; chip_en = 1; cyc(WAKE + SET + 4);
        rx_primary = 0; txq_empty = 0; cyc(SET + 3);
        pkt_done = 1; rx_primary = 1; cyc(1); pkt_done = 0; cyc(SET + 3);
        rx_primary = 0; txq_empty = 1; cyc(3);
        // constrained random phase with irregular ticks
        phase = ""; tick_rand = 1'b1;
        for (int i = 0; i < 30000; i++) begin
            cyc(1);
            if ($urandom % 400 == 0) pwr_on = ~pwr_on;
            if (!pwr_on && $urandom % 8 == 0) pwr_on = 1;
            if ($urandom % 40 == 0) rx_primary = ~rx_primary;
            if ($urandom % 15 == 0) chip_en = ~chip_en;
            if ($urandom % 10 == 0) txq_empty = ~txq_empty;
            if ($urandom % 300 == 0) ext_osc = ~ext_osc;
            pkt_done = ($urandom % 30 == 0);
        end
        cyc(2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule